// File: doc/BRIEF.md
# Burst DMA Command Capture Unit

This unit sits on the register side of a flash controller. Software, or a bus master in programmable logic, starts a DMA transfer by writing four 16-bit beats to one data register. The beats may come as one four-beat incrementing burst or as four separate single writes. The unit tracks which beat is expected next. It takes the transfer direction, page count, 32-bit host buffer address, burst length and a per-transfer interrupt-request flag from those beats. It rejects malformed commands and raises a sticky error bit when it does.

A well-formed command is offered to the DMA engine on a valid/ready handshake. It stays on the outputs until the engine takes it. While that command waits or runs, new writes to the data register are dropped. When the engine reports the end of the whole transfer, the unit sets a sticky completion status bit, but only if the command asked for it. Software clears the status bits by writing ones to a status address. An idle output tells other logic when the DMA path holds no work, so settings such as bus attributes can be changed safely.

Top module: `dmacmd_capture`

## Requirements
- R1: Beats are taken only from writes to address 0x10. They are consumed in the order beat 0, beat 1, beat 2, beat 3. Writes to any other address leave the beat sequence untouched.
- R2: Beat 0 carries a command code in bits [15:12], which must be 0x2, and a direction field in [11:8], where 0x0 means read and 0x1 means write. Direction appears on `cmd_dir` as 0 for read and 1 for write. The page count in [7:0] appears on `cmd_pages`.
- R3: A beat 0 with any other code or direction is discarded. It sets `cmd_err` and leaves the unit expecting beat 0 again.
- R4: Beat 1 supplies host address bits [31:16] and beat 2 supplies bits [15:0]. If beat 2 has bit 1 or bit 0 set, the command is discarded, `cmd_err` is set and the unit expects beat 0 again.
- R5: Beat 3 carries the interrupt-request flag in bit 8 and the burst length in [7:0]. If any of bits [15:9] is set, the command is discarded, `cmd_err` is set and the unit expects beat 0 again.
- R6: `cmd_valid` rises on the clock edge that takes a valid beat 3. It stays high, with all command fields stable, until a cycle in which `cmd_ready` is high.
- R7: Writes to the data register have no effect while a command is pending or its transfer is still running.
- R8: `xfer_done` ends a running transfer. `done_irq` is then set to 1 if that command's flag was 1, and it stays unchanged if the flag was 0. Once set, `done_irq` stays set until it is cleared.
- R9: While `dma_enable` is low, no beat is captured and a partly received command is dropped.
- R10: A write to address 0x14 clears `done_irq` when data bit 0 is 1 and clears `cmd_err` when data bit 1 is 1. Both bits reset to 0. A set event in the same cycle wins over a clear.
- R11: `dma_idle` is high exactly when no command is pending and no transfer is running.
- R12: Four beats give the same command whether they arrive on consecutive cycles as a burst or as single writes with gaps between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 16 | Register write data |
| dma_enable | input | 1 | Enables command capture |
| cmd_valid | output | 1 | Command offered to the DMA engine |
| cmd_ready | input | 1 | DMA engine accepts the command |
| cmd_dir | output | 1 | 0 = read, 1 = write |
| cmd_pages | output | 8 | Page count |
| cmd_addr | output | 32 | Host buffer address |
| cmd_blen | output | 8 | Burst length |
| cmd_irq | output | 1 | Interrupt-request flag of the command |
| xfer_done | input | 1 | Engine reports the whole transfer finished |
| done_irq | output | 1 | Sticky completion status, write-1-to-clear |
| cmd_err | output | 1 | Sticky malformed-command status, write-1-to-clear |
| dma_idle | output | 1 | No command pending or in flight |

## Verification
On every cycle, the assertions check the following:
- A waiting command holds steady until it is accepted.
- Every offered address is word aligned.
- No new command is produced while one is pending or running.
- Dropping the enable empties the beat sequence.
- The completion bit stays set until it is cleared.

Other behaviour is shown only by the bench's scenarios. These cover field extraction from the beats, the choice between raising and not raising completion for each transfer, the way a malformed beat resynchronises the sequence, that burst and single-write delivery match, and that writes landing while a command is pending or in flight leave no trace on a later command.

// File: rtl/dmacmd_pkg.sv
package dmacmd_pkg;
    localparam int BEAT_W  = 16;
    localparam int PAGE_W  = 8;
    localparam int BLEN_W  = 8;
    localparam int HADDR_W = 2 * BEAT_W;
    localparam logic [3:0] CODE_DMA = 4'h2;

    typedef struct packed {
        logic               dir;
        logic [PAGE_W-1:0]  pages;
        logic [HADDR_W-1:0] haddr;
        logic [BLEN_W-1:0]  blen;
        logic               irq;
    } dma_cmd_t;
endpackage

// File: rtl/dmacmd_beat_seq.sv
module dmacmd_beat_seq
    import dmacmd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] DATA_OFFS = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BEAT_W-1:0] wr_data,
    input  logic              dma_enable,
    input  logic              blocked,
    output logic              fire,
    output logic              err_set,
    output dma_cmd_t          cmd_next
);
    localparam int CNT_W = 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        dma_cmd_t         cmd;
    } seq_t;

    seq_t s_q, s_d;
    logic hit;

    always_comb begin
        s_d     = s_q;
        fire    = 1'b0;
        err_set = 1'b0;
        hit     = wr_en && (wr_addr == DATA_OFFS) && !blocked;
        if (!dma_enable) begin
            s_d.cnt = '0;
        end else if (hit) begin
            case (s_q.cnt)
                2'd0: begin
                    if (wr_data[15:12] == CODE_DMA && wr_data[11:9] == 3'b000) begin
                        s_d.cmd.dir   = wr_data[8];
                        s_d.cmd.pages = wr_data[PAGE_W-1:0];
                        s_d.cnt       = 2'd1;
                    end else begin
                        err_set = 1'b1;
                    end
                end
                2'd1: begin
                    s_d.cmd.haddr[HADDR_W-1:BEAT_W] = wr_data;
                    s_d.cnt = 2'd2;
                end
                2'd2: begin
                    if (wr_data[1:0] != 2'b00) begin
                        err_set = 1'b1;
                        s_d.cnt = 2'd0;
                    end else begin
                        s_d.cmd.haddr[BEAT_W-1:0] = wr_data;
                        s_d.cnt = 2'd3;
                    end
                end
                default: begin
                    s_d.cnt = 2'd0;
                    if (wr_data[15:9] != 7'd0) begin
                        err_set = 1'b1;
                    end else begin
                        s_d.cmd.irq  = wr_data[8];
                        s_d.cmd.blen = wr_data[BLEN_W-1:0];
                        fire = 1'b1;
                    end
                end
            endcase
        end
        cmd_next = s_d.cmd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_enable |=> s_q.cnt == '0); // R9
endmodule

// File: rtl/dmacmd_issue.sv
module dmacmd_issue
    import dmacmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fire,
    input  dma_cmd_t cmd_in,
    input  logic     cmd_ready,
    input  logic     xfer_done,
    output logic     cmd_valid,
    output dma_cmd_t cmd_out,
    output logic     blocked,
    output logic     done_set,
    output logic     idle
);
    typedef struct packed {
        logic     pend;
        logic     busy;
        logic     irq;
        dma_cmd_t cmd;
    } iss_t;

    iss_t i_q, i_d;

    always_comb begin
        i_d      = i_q;
        done_set = 1'b0;
        if (fire) begin
            i_d.pend = 1'b1;
            i_d.cmd  = cmd_in;
        end
        if (i_q.pend && cmd_ready) begin
            i_d.pend = 1'b0;
            i_d.busy = 1'b1;
            i_d.irq  = i_q.cmd.irq;
        end
        if (i_q.busy && xfer_done) begin
            i_d.busy = 1'b0;
            done_set = i_q.irq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    assign cmd_valid = i_q.pend;
    assign cmd_out   = i_q.cmd;
    assign blocked   = i_q.pend || i_q.busy;
    assign idle      = !(i_q.pend || i_q.busy);

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_out)); // R6
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_out.haddr[1:0] == 2'b00); // R4
    AST_NO_FIRE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !i_q.pend && !i_q.busy); // R7
endmodule

// File: rtl/dmacmd_status.sv
module dmacmd_status #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] STAT_OFFS = 8'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_bits,
    input  logic              done_set,
    input  logic              err_set,
    output logic              done_stat,
    output logic              err_stat
);
    typedef struct packed {
        logic done;
        logic err;
    } stat_t;

    stat_t t_q, t_d;
    logic  clr_done, clr_err;

    always_comb begin
        clr_done = wr_en && (wr_addr == STAT_OFFS) && wr_bits[0];
        clr_err  = wr_en && (wr_addr == STAT_OFFS) && wr_bits[1];
        t_d.done = (t_q.done && !clr_done) || done_set;
        t_d.err  = (t_q.err  && !clr_err)  || err_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign done_stat = t_q.done;
    assign err_stat  = t_q.err;

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_stat && !clr_done |=> done_stat); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_stat && !clr_err |=> err_stat); // R10
endmodule

// File: rtl/dmacmd_capture.sv
module dmacmd_capture
    import dmacmd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] DATA_OFFS = 8'h10,
    parameter logic [ADDR_W-1:0] STAT_OFFS = 8'h14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [BEAT_W-1:0]  wr_data,
    input  logic               dma_enable,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic               cmd_dir,
    output logic [PAGE_W-1:0]  cmd_pages,
    output logic [HADDR_W-1:0] cmd_addr,
    output logic [BLEN_W-1:0]  cmd_blen,
    output logic               cmd_irq,
    input  logic               xfer_done,
    output logic               done_irq,
    output logic               cmd_err,
    output logic               dma_idle
);
    logic     fire, err_set, blocked, done_set;
    dma_cmd_t cmd_next, cmd_out;

    dmacmd_beat_seq #(.ADDR_W(ADDR_W), .DATA_OFFS(DATA_OFFS)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dma_enable(dma_enable), .blocked(blocked),
        .fire(fire), .err_set(err_set), .cmd_next(cmd_next)
    );

    dmacmd_issue u_iss (
        .clk(clk), .rst_n(rst_n), .fire(fire), .cmd_in(cmd_next),
        .cmd_ready(cmd_ready), .xfer_done(xfer_done), .cmd_valid(cmd_valid),
        .cmd_out(cmd_out), .blocked(blocked), .done_set(done_set), .idle(dma_idle)
    );

    dmacmd_status #(.ADDR_W(ADDR_W), .STAT_OFFS(STAT_OFFS)) u_stat (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_bits(wr_data[1:0]), .done_set(done_set), .err_set(err_set),
        .done_stat(done_irq), .err_stat(cmd_err)
    );

    assign cmd_dir   = cmd_out.dir;
    assign cmd_pages = cmd_out.pages;
    assign cmd_addr  = cmd_out.haddr;
    assign cmd_blen  = cmd_out.blen;
    assign cmd_irq   = cmd_out.irq;
endmodule

// File: tb/sim_dmacmd_capture.sv
module sim_dmacmd_capture;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {ok, beat0, beat1, beat2, beat3}
    localparam logic [64:0] VEC [NVEC] = '{
        {1'b1, 16'h2005, 16'h1234, 16'h5678, 16'h0110},
        {1'b1, 16'h21FF, 16'hABCD, 16'h0000, 16'h0040},
        {1'b0, 16'h3005, 16'h1111, 16'h1110, 16'h0001},
        {1'b0, 16'h2205, 16'h1111, 16'h1110, 16'h0001},
        {1'b0, 16'h2002, 16'h1000, 16'h0002, 16'h0008},
        {1'b0, 16'h2002, 16'h1000, 16'h0001, 16'h0008},
        {1'b0, 16'h2103, 16'h0000, 16'h0100, 16'h0201},
        {1'b1, 16'h2101, 16'hFFFF, 16'hFFFC, 16'h00FF}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0, dma_enable = 1'b1, cmd_ready = 1'b0, xfer_done = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        cmd_valid, cmd_dir, cmd_irq, done_irq, cmd_err, dma_idle;
    logic [7:0]  cmd_pages, cmd_blen;
    logic [31:0] cmd_addr;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmacmd_capture u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dma_enable(dma_enable), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_dir(cmd_dir), .cmd_pages(cmd_pages), .cmd_addr(cmd_addr),
        .cmd_blen(cmd_blen), .cmd_irq(cmd_irq), .xfer_done(xfer_done),
        .done_irq(done_irq), .cmd_err(cmd_err), .dma_idle(dma_idle)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic quiet();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic [63:0] b, input bit burst);
        for (int k = 3; k >= 0; k--) begin
            put(8'h10, b[k*16 +: 16]);
            if (!burst) quiet();
        end
        if (burst) quiet();
    endtask

    task automatic accept();
        @(negedge clk); cmd_ready = 1'b1;
        @(negedge clk); cmd_ready = 1'b0;
    endtask

    task automatic finish_xfer();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic clear(input logic [15:0] bits);
        put(8'h14, bits); quiet();
    endtask

    task automatic chk_cmd(input string req, input logic [63:0] b);
        chk(req, cmd_dir, b[56]);
        chk(req, cmd_pages, b[55:48]);
        chk(req, cmd_addr, b[47:16]);
        chk(req, cmd_blen, b[7:0]);
        chk(req, cmd_irq, b[8]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state R10 R11
        chk("R10 reset done", done_irq, 0);
        chk("R10 reset err", cmd_err, 0);
        chk("R11 idle reset", dma_idle, 1);
        chk("R6 valid reset", cmd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 R3 R4 R5 R8 R12 (even single writes, odd burst)
        for (int i = 0; i < NVEC; i++) begin
            logic [63:0] b;
            b = VEC[i][63:0];
            send(b, i[0]);
            if (VEC[i][64]) begin
                chk("R6 valid up", cmd_valid, 1);
                chk("R11 not idle", dma_idle, 0);
                chk_cmd("R2/R4/R5/R12 fields", b);
                accept();
                chk("R6 valid drop", cmd_valid, 0);
                chk("R11 in flight", dma_idle, 0);
                finish_xfer();
                chk("R8 done flag", done_irq, b[8]);
                chk("R11 idle after", dma_idle, 1);
                clear(16'h0001);
                chk("R10 clear done", done_irq, 0);
            end else begin
                chk("R3/R4/R5 no cmd", cmd_valid, 0);
                chk("R3/R4/R5 err set", cmd_err, 1);
                clear(16'h0002);
                chk("R10 clear err", cmd_err, 0);
            end
        end

        // R1: foreign address write in mid-sequence ignored
        put(8'h10, 16'h2007); quiet();
        put(8'h18, 16'hFFFF); quiet();
        put(8'h10, 16'h00A0); quiet();
        put(8'h10, 16'h0B04); quiet();
        put(8'h10, 16'h0120); quiet();
        chk("R1 valid", cmd_valid, 1);
        chk("R1 addr", cmd_addr, 32'h00A00B04);
        // R6 hold while not ready, R7 writes ignored while pending
        send({16'h2133, 16'h5555, 16'h6664, 16'h0077}, 1'b1);
        repeat (2) @(negedge clk);
        chk("R6 still valid", cmd_valid, 1);
        chk("R7 fields kept", {cmd_dir, cmd_pages, cmd_blen}, {1'b0, 8'h07, 8'h20});
        accept();
        // R7: write while in flight ignored
        put(8'h10, 16'h2009); quiet();
        chk("R7 no new valid", cmd_valid, 0);
        finish_xfer();
        chk("R8 irq set", done_irq, 1);
        // R10: clearing bit1 only leaves done
        clear(16'h0002);
        chk("R10 done kept", done_irq, 1);
        clear(16'h0001);
        send({16'h2010, 16'h0000, 16'h0040, 16'h0008}, 1'b1);
        chk("R7 clean start", cmd_addr, 32'h00000040);
        chk("R7 clean pages", cmd_pages, 8'h10);
        accept(); finish_xfer();
        chk("R8 no irq", done_irq, 0);

        // R9: disabled, whole command ignored
        dma_enable = 1'b0;
        send({16'h2001, 16'h0000, 16'h0010, 16'h0001}, 1'b1);
        chk("R9 disabled", cmd_valid, 0);
        // R9: partial dropped when enable falls
        dma_enable = 1'b1;
        put(8'h10, 16'h2001); quiet();
        put(8'h10, 16'h1111); quiet();
        @(negedge clk); dma_enable = 1'b0;
        @(negedge clk); dma_enable = 1'b1;
        send({16'h2122, 16'h0303, 16'h0404, 16'h0105}, 1'b0);
        chk("R9 flushed", cmd_addr, 32'h03030404);
        chk("R9 pages", cmd_pages, 8'h22);
        chk("R9 no err", cmd_err, 0);
        accept(); finish_xfer();
        chk("R8 irq again", done_irq, 1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule